// File: doc/BRIEF.md
# Memory Tag Load Execution Unit

This unit carries out a single load-allocation-tag instruction. A 32-bit instruction word comes in with a feature-enable bit. The unit checks the encoding. It then reads a base value, which is either a general-purpose register or the stack pointer. It adds a signed immediate that has been scaled to the 16-byte tag granule, and clears the low address bits so that the address points at the start of a granule. That aligned address goes to a tag storage memory over a valid/ready request. The 4-bit tag that comes back is placed into the logical-tag field of the destination register's current value. The result is then written back to the register file.

The unit handles one instruction at a time. It signals completion with a one-cycle `done` pulse. The same pulse marks an instruction that ends early because it is undefined or because the stack pointer is misaligned. In both of those early cases no tag request is made and no register is written.

Top module: `mtag_load_unit`

## Requirements
- R1: The instruction is valid only when bits [31:24]=8'hD9, [23:22]=2'b01, [21]=1 and [11:10]=2'b00. Any other word raises `undef` together with `done`, and produces no tag request and no write-back.
- R2: If `feat_en` is low when the instruction is accepted, the instruction raises `undef` together with `done`, with no tag request and no write-back.
- R3: The byte offset is imm9 (bits [20:12]) sign-extended and shifted left by 4. The range is -4096 to +4080 in steps of 16.
- R4: Base field bits [9:5] equal to 31 select `sp_data` as the base. Any other value selects the register-file value `gpr_rn_data` at index `gpr_rn_idx`.
- R5: The request address is base plus offset with bits [3:0] forced to zero.
- R6: When the base is the stack pointer and `sp_data[3:0]` is nonzero, the unit pulses `align_fault` with `done`. It makes no tag request and no write-back.
- R7: The write-back value equals the destination register's prior value with bits [59:56] replaced by the returned tag. All other bits are unchanged.
- R8: `wb_en` pulses for exactly one cycle, in the cycle after `tag_rsp_valid`, with `wb_idx` equal to bits [4:0]. A destination of 31 gives `done` without `wb_en`.
- R9: `tag_req_valid` stays high and `tag_req_addr` stays stable until `tag_req_ready` is sampled high. Exactly one request is made per instruction.
- R10: `insn_ready` is high only while idle. An `insn_valid` asserted while the unit is busy is ignored.
- R11: Each accepted instruction produces exactly one `done` pulse. An undefined instruction reports `undef` alone, even when its stack-pointer base is also misaligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction offered |
| insn_word | input | 32 | Instruction word |
| feat_en | input | 1 | Feature enable, sampled on accept |
| insn_ready | output | 1 | Unit idle, instruction accepted |
| gpr_rn_idx | output | 5 | Base register read index |
| gpr_rn_data | input | 64 | Base register read data |
| gpr_rt_idx | output | 5 | Destination register read index |
| gpr_rt_data | input | 64 | Destination register current value |
| sp_data | input | 64 | Stack pointer value |
| tag_req_valid | output | 1 | Tag request valid |
| tag_req_ready | input | 1 | Tag memory accepts request |
| tag_req_addr | output | 64 | Granule-aligned tag address |
| tag_rsp_valid | input | 1 | Tag response valid |
| tag_rsp_tag | input | 4 | Returned allocation tag |
| wb_en | output | 1 | Register write enable pulse |
| wb_idx | output | 5 | Register write index |
| wb_data | output | 64 | Register write data |
| done | output | 1 | Completion pulse |
| undef | output | 1 | Undefined-instruction pulse |
| align_fault | output | 1 | Stack-pointer alignment fault pulse |

## Verification
Two exits from the execute step can be true in the same cycle: a failed encoding or feature check, and a stack-pointer alignment fault. The bench provokes this with a malformed word whose base field is 31 while `sp_data` is misaligned. It also repeats the case with a well-formed word and `feat_en` low. In both runs it expects a lone `undef` with `done`, no `align_fault`, no request and no write. A second overlap is an `insn_valid` that arrives while a stalled request is outstanding. The bench judges that case by counting completions and requests afterwards.

// File: rtl/mtag_pkg.sv
`timescale 1ns/1ps
package mtag_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EXEC,
    ST_REQ,
    ST_WAIT
  } mtag_state_e;

  localparam int IMM_W = 9;
  localparam int REG_IDX_W = 5;
  localparam logic [REG_IDX_W-1:0] REG_SP_ZR = 5'd31;

  typedef struct packed {
    logic                 enc_ok;
    logic [IMM_W-1:0]     imm;
    logic [REG_IDX_W-1:0] rn;
    logic [REG_IDX_W-1:0] rt;
  } mtag_fields_t;
endpackage

// File: rtl/mtag_decode.sv
`timescale 1ns/1ps
module mtag_decode
  import mtag_pkg::*;
#(
  parameter int INSN_W = 32
) (
  input  logic [INSN_W-1:0] insn,
  output mtag_fields_t      fields
);
  localparam logic [7:0] MAJOR_OP = 8'hD9;
  localparam logic [1:0] OPC_VAL  = 2'b01;
  localparam logic [1:0] OP2_VAL  = 2'b00;

  always_comb begin
    fields.enc_ok = (insn[31:24] == MAJOR_OP) && (insn[23:22] == OPC_VAL) &&
                    insn[21] && (insn[11:10] == OP2_VAL);
    fields.imm    = insn[20:12];
    fields.rn     = insn[9:5];
    fields.rt     = insn[4:0];
  end
endmodule

// File: rtl/mtag_addr_gen.sv
`timescale 1ns/1ps
module mtag_addr_gen #(
  parameter int XLEN       = 64,
  parameter int IMM_BITS   = 9,
  parameter int GRAN_LOG2  = 4,
  parameter int SP_AL_LOG2 = 4
) (
  input  logic [IMM_BITS-1:0] imm,
  input  logic                use_sp,
  input  logic [XLEN-1:0]     gpr_base,
  input  logic [XLEN-1:0]     sp_base,
  output logic [XLEN-1:0]     addr,
  output logic                sp_misaligned
);
  localparam int EXT_W = XLEN - IMM_BITS;

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;
  logic [XLEN-1:0] sum;

  always_comb begin
    base          = use_sp ? sp_base : gpr_base;
    offset        = {{EXT_W{imm[IMM_BITS-1]}}, imm} << GRAN_LOG2;
    sum           = base + offset;
    addr          = {sum[XLEN-1:GRAN_LOG2], {GRAN_LOG2{1'b0}}};
    sp_misaligned = use_sp && (|sp_base[SP_AL_LOG2-1:0]);
  end
endmodule

// File: rtl/mtag_merge.sv
`timescale 1ns/1ps
module mtag_merge #(
  parameter int XLEN    = 64,
  parameter int TAG_W   = 4,
  parameter int TAG_LSB = 56
) (
  input  logic [XLEN-1:0]  reg_val,
  input  logic [TAG_W-1:0] tag,
  output logic [XLEN-1:0]  merged
);
  for (genvar b = 0; b < XLEN; b++) begin : g_bit
    if (b >= TAG_LSB && b < TAG_LSB + TAG_W) begin : g_tag
      assign merged[b] = tag[b - TAG_LSB];
    end else begin : g_keep
      assign merged[b] = reg_val[b];
    end
  end
endmodule

// File: rtl/mtag_load_unit.sv
`timescale 1ns/1ps
module mtag_load_unit
  import mtag_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int INSN_W    = 32,
  parameter int TAG_W     = 4,
  parameter int TAG_LSB   = 56,
  parameter int GRAN_LOG2 = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 insn_valid,
  input  logic [INSN_W-1:0]    insn_word,
  input  logic                 feat_en,
  output logic                 insn_ready,
  output logic [REG_IDX_W-1:0] gpr_rn_idx,
  input  logic [XLEN-1:0]      gpr_rn_data,
  output logic [REG_IDX_W-1:0] gpr_rt_idx,
  input  logic [XLEN-1:0]      gpr_rt_data,
  input  logic [XLEN-1:0]      sp_data,
  output logic                 tag_req_valid,
  input  logic                 tag_req_ready,
  output logic [XLEN-1:0]      tag_req_addr,
  input  logic                 tag_rsp_valid,
  input  logic [TAG_W-1:0]     tag_rsp_tag,
  output logic                 wb_en,
  output logic [REG_IDX_W-1:0] wb_idx,
  output logic [XLEN-1:0]      wb_data,
  output logic                 done,
  output logic                 undef,
  output logic                 align_fault
);
  mtag_state_e       state;
  logic [INSN_W-1:0] insn_q;
  logic              feat_q;
  logic [XLEN-1:0]   xt_q;
  mtag_fields_t      fld;
  logic [XLEN-1:0]   eff_addr;
  logic              sp_mis;
  logic [XLEN-1:0]   merged;
  logic              use_sp;

  mtag_decode #(.INSN_W(INSN_W)) u_dec (
    .insn   (insn_q),
    .fields (fld)
  );

  assign use_sp = (fld.rn == REG_SP_ZR);

  mtag_addr_gen #(
    .XLEN(XLEN), .IMM_BITS(IMM_W), .GRAN_LOG2(GRAN_LOG2), .SP_AL_LOG2(GRAN_LOG2)
  ) u_agen (
    .imm           (fld.imm),
    .use_sp        (use_sp),
    .gpr_base      (gpr_rn_data),
    .sp_base       (sp_data),
    .addr          (eff_addr),
    .sp_misaligned (sp_mis)
  );

  mtag_merge #(.XLEN(XLEN), .TAG_W(TAG_W), .TAG_LSB(TAG_LSB)) u_merge (
    .reg_val (xt_q),
    .tag     (tag_rsp_tag),
    .merged  (merged)
  );

  assign insn_ready = (state == ST_IDLE);
  assign gpr_rn_idx = fld.rn;
  assign gpr_rt_idx = fld.rt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      insn_q        <= '0;
      feat_q        <= 1'b0;
      xt_q          <= '0;
      tag_req_valid <= 1'b0;
      tag_req_addr  <= '0;
      wb_en         <= 1'b0;
      wb_idx        <= '0;
      wb_data       <= '0;
      done          <= 1'b0;
      undef         <= 1'b0;
      align_fault   <= 1'b0;
    end else begin
      done        <= 1'b0;
      undef       <= 1'b0;
      align_fault <= 1'b0;
      wb_en       <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (insn_valid) begin
            insn_q <= insn_word;
            feat_q <= feat_en;
            state  <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          if (!feat_q || !fld.enc_ok) begin
            undef <= 1'b1;
            done  <= 1'b1;
            state <= ST_IDLE;
          end else if (sp_mis) begin
            align_fault <= 1'b1;
            done        <= 1'b1;
            state       <= ST_IDLE;
          end else begin
            tag_req_valid <= 1'b1;
            tag_req_addr  <= eff_addr;
            xt_q          <= (fld.rt == REG_SP_ZR) ? '0 : gpr_rt_data;
            state         <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (tag_req_ready) begin
            tag_req_valid <= 1'b0;
            state         <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (tag_rsp_valid) begin
            wb_data <= merged;
            wb_idx  <= fld.rt;
            wb_en   <= (fld.rt != REG_SP_ZR);
            done    <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mtag_load_unit_chk.sv
`timescale 1ns/1ps
module mtag_load_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            insn_valid,
  input logic            insn_ready,
  input logic            tag_req_valid,
  input logic            tag_req_ready,
  input logic [XLEN-1:0] tag_req_addr,
  input logic            tag_rsp_valid,
  input logic            wb_en,
  input logic [4:0]      wb_idx,
  input logic            done,
  input logic            undef,
  input logic            align_fault
);
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (tag_req_valid && !tag_req_ready) |=> (tag_req_valid && $stable(tag_req_addr)));

  assert_addr_granule_R5: assert property (@(posedge clk) disable iff (rst)
    tag_req_valid |-> (tag_req_addr[3:0] == 4'h0));

  assert_wb_after_rsp_R8: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> ($past(tag_rsp_valid) && done && (wb_idx != 5'd31)));

  assert_wb_single_R8: assert property (@(posedge clk) disable iff (rst)
    wb_en |=> !wb_en);

  assert_early_exit_R11: assert property (@(posedge clk) disable iff (rst)
    (undef || align_fault) |-> (done && !wb_en && !(undef && align_fault)));

  assert_busy_no_accept_R10: assert property (@(posedge clk) disable iff (rst)
    (insn_ready && insn_valid) |=> !insn_ready);

  assert_req_when_busy_R10: assert property (@(posedge clk) disable iff (rst)
    tag_req_valid |-> !insn_ready);

  assert_fault_no_req_R6: assert property (@(posedge clk) disable iff (rst)
    align_fault |-> !tag_req_valid);
endmodule

bind mtag_load_unit mtag_load_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .insn_valid    (insn_valid),
  .insn_ready    (insn_ready),
  .tag_req_valid (tag_req_valid),
  .tag_req_ready (tag_req_ready),
  .tag_req_addr  (tag_req_addr),
  .tag_rsp_valid (tag_rsp_valid),
  .wb_en         (wb_en),
  .wb_idx        (wb_idx),
  .done          (done),
  .undef         (undef),
  .align_fault   (align_fault)
);

// File: tb/mtag_load_unit_tb.sv
`timescale 1ns/1ps
module mtag_load_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        insn_valid = 1'b0;
  logic [31:0] insn_word = '0;
  logic        feat_en = 1'b0;
  logic        insn_ready;
  logic [4:0]  gpr_rn_idx, gpr_rt_idx, wb_idx;
  logic [63:0] gpr_rn_data, gpr_rt_data, sp_data, tag_req_addr, wb_data;
  logic        tag_req_valid, tag_req_ready, tag_rsp_valid;
  logic [3:0]  tag_rsp_tag;
  logic        wb_en, done, undef, align_fault;

  logic [63:0] regs [32];
  logic [63:0] sp_val;

  int n_chk = 0, n_bad = 0;
  int done_n = 0, undef_n = 0, fault_n = 0, wb_n = 0, req_n = 0;
  int cyc = 0, rsp_cyc = 0, wb_cyc = 0;
  int ready_delay = 0, rsp_delay = 0;
  logic [63:0] last_addr, last_wb;
  logic [4:0]  last_idx;

  bit rdy_q = 0, val_q = 0, pend = 0;
  logic [63:0] addr_q;
  int stall = 0, wait_n = 0;

  always #10 clk = ~clk;

  assign gpr_rn_data = (gpr_rn_idx == 5'd31) ? 64'h0 : regs[gpr_rn_idx];
  assign gpr_rt_data = (gpr_rt_idx == 5'd31) ? 64'h0 : regs[gpr_rt_idx];
  assign sp_data     = sp_val;

  mtag_load_unit u_dut (
    .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_word(insn_word),
    .feat_en(feat_en), .insn_ready(insn_ready), .gpr_rn_idx(gpr_rn_idx),
    .gpr_rn_data(gpr_rn_data), .gpr_rt_idx(gpr_rt_idx), .gpr_rt_data(gpr_rt_data),
    .sp_data(sp_data), .tag_req_valid(tag_req_valid), .tag_req_ready(tag_req_ready),
    .tag_req_addr(tag_req_addr), .tag_rsp_valid(tag_rsp_valid), .tag_rsp_tag(tag_rsp_tag),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .done(done), .undef(undef),
    .align_fault(align_fault)
  );

  function automatic logic [3:0] tag_of(input logic [63:0] a);
    return a[7:4] ^ a[15:12] ^ 4'h5;
  endfunction

  function automatic logic [31:0] enc(input logic [8:0] imm, input logic [4:0] rn, input logic [4:0] rt);
    return {8'hD9, 2'b01, 1'b1, imm, 2'b00, rn, rt};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Tag memory model and output monitor
  initial begin
    tag_req_ready = 1'b0;
    tag_rsp_valid = 1'b0;
    tag_rsp_tag   = 4'h0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst) begin
        if (done) done_n++;
        if (undef) undef_n++;
        if (align_fault) fault_n++;
        if (wb_en) begin
          wb_n++; last_wb = wb_data; last_idx = wb_idx; wb_cyc = cyc;
          regs[wb_idx] = wb_data;
        end
      end
      tag_rsp_valid = 1'b0;
      if (rdy_q && val_q) begin
        req_n++; last_addr = addr_q; pend = 1; wait_n = rsp_delay;
      end
      if (pend) begin
        if (wait_n == 0) begin
          tag_rsp_valid = 1'b1; tag_rsp_tag = tag_of(last_addr); rsp_cyc = cyc; pend = 0;
        end else wait_n--;
      end
      val_q  = tag_req_valid;
      addr_q = tag_req_addr;
      if (tag_req_valid) begin
        tag_req_ready = (stall >= ready_delay);
        stall++;
      end else begin
        tag_req_ready = 1'b0;
        stall = 0;
      end
      rdy_q = tag_req_ready;
    end
  end

  task automatic issue(input logic [31:0] w, input bit fe);
    int d0 = done_n;
    int guard = 0;
    while (!insn_ready) @(negedge clk);
    insn_word = w; feat_en = fe; insn_valid = 1'b1;
    @(negedge clk);
    insn_valid = 1'b0;
    while (done_n == d0 && guard < 300) begin @(negedge clk); guard++; end
    if (guard >= 300) begin
      n_chk++; n_bad++;
      $display("FAIL R11: actual no done expected done");
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  // Successful load: checks address, merge, write-back timing and counts
  task automatic load_ok(input string req, input logic [8:0] imm, input logic [4:0] rn, input logic [4:0] rt);
    logic [63:0] base, off, exp_addr, xt, exp_wb;
    int d_done = done_n, d_wb = wb_n, d_req = req_n, d_un = undef_n;
    base = (rn == 5'd31) ? sp_val : regs[rn];
    off = {{55{imm[8]}}, imm} << 4;
    exp_addr = (base + off) & ~64'hF;
    xt = (rt == 5'd31) ? 64'h0 : regs[rt];
    exp_wb = xt;
    exp_wb[59:56] = tag_of(exp_addr);
    issue(enc(imm, rn, rt), 1'b1);
    chk({req, " R3/R5 addr"}, last_addr, exp_addr);
    chk({req, " R9 one request"}, 64'(req_n - d_req), 64'd1);
    chk({req, " R11 one done"}, 64'(done_n - d_done), 64'd1);
    chk({req, " R1 no undef"}, 64'(undef_n - d_un), 64'd0);
    if (rt != 5'd31) begin
      chk({req, " R8 one wb"}, 64'(wb_n - d_wb), 64'd1);
      chk({req, " R7 wb data"}, last_wb, exp_wb);
      chk({req, " R8 wb idx"}, 64'(last_idx), 64'(rt));
      chk({req, " R8 wb cycle"}, 64'(wb_cyc), 64'(rsp_cyc + 1));
    end else begin
      chk({req, " R8 zr no wb"}, 64'(wb_n - d_wb), 64'd0);
    end
  endtask

  // Early exit: undefined or alignment fault
  task automatic early_exit(input string req, input logic [31:0] w, input bit fe,
                            input int exp_un, input int exp_flt);
    int d_done = done_n, d_wb = wb_n, d_req = req_n, d_un = undef_n, d_f = fault_n;
    issue(w, fe);
    chk({req, " undef"}, 64'(undef_n - d_un), 64'(exp_un));
    chk({req, " align_fault"}, 64'(fault_n - d_f), 64'(exp_flt));
    chk({req, " no request"}, 64'(req_n - d_req), 64'd0);
    chk({req, " no wb"}, 64'(wb_n - d_wb), 64'd0);
    chk({req, " R11 one done"}, 64'(done_n - d_done), 64'd1);
  endtask

  task automatic test_reset();
    chk("R10 reset ready", 64'(insn_ready), 64'd1);
    chk("R9 reset no req", 64'(tag_req_valid), 64'd0);
    chk("R8 reset no wb", 64'(wb_en), 64'd0);
    chk("R11 reset no done", 64'(done), 64'd0);
  endtask

  task automatic test_busy_ignore();
    int d_done = done_n, d_un = undef_n, d_req = req_n;
    ready_delay = 6;
    while (!insn_ready) @(negedge clk);
    insn_word = enc(9'd3, 5'd2, 5'd4); feat_en = 1'b1; insn_valid = 1'b1;
    @(negedge clk);
    insn_word = 32'hFFFF_FFFF; insn_valid = 1'b1;
    @(negedge clk);
    chk("R10 busy not ready", 64'(insn_ready), 64'd0);
    @(negedge clk);
    chk("R9 stalled req held", 64'(tag_req_valid), 64'd1);
    @(negedge clk);
    insn_valid = 1'b0;
    while (done_n == d_done) @(negedge clk);
    repeat (6) @(negedge clk);
    chk("R10 busy insn ignored: done count", 64'(done_n - d_done), 64'd1);
    chk("R10 busy insn ignored: undef", 64'(undef_n - d_un), 64'd0);
    chk("R9 stalled one request", 64'(req_n - d_req), 64'd1);
    ready_delay = 0;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h1111_0000_0101_0013);
    sp_val = 64'h0000_7FFF_FFFF_E000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    load_ok("R4 gpr base positive imm", 9'd5, 5'd1, 5'd2);
    load_ok("R3 min imm -4096", 9'h100, 5'd3, 5'd5);
    load_ok("R3 max imm +4080", 9'h0FF, 5'd6, 5'd7);
    load_ok("R3 imm -1", 9'h1FF, 5'd8, 5'd9);
    load_ok("R4 sp base", 9'd17, 5'd31, 5'd10);
    load_ok("R7 same reg base/dest", 9'd0, 5'd11, 5'd11);
    rsp_delay = 4; ready_delay = 3;
    load_ok("R9 slow memory", 9'h1F0, 5'd12, 5'd13);
    rsp_delay = 0; ready_delay = 0;
    load_ok("R8 dest zero reg", 9'd2, 5'd14, 5'd31);
    early_exit("R1 bad opc", enc(9'd1, 5'd1, 5'd2) ^ 32'h00C0_0000, 1'b1, 1, 0);
    early_exit("R1 bad op2", enc(9'd1, 5'd1, 5'd2) | 32'h0000_0400, 1'b1, 1, 0);
    early_exit("R1 bad bit21", enc(9'd1, 5'd1, 5'd2) & ~32'h0020_0000, 1'b1, 1, 0);
    early_exit("R2 feature off", enc(9'd1, 5'd1, 5'd2), 1'b0, 1, 0);
    sp_val = 64'h0000_7FFF_FFFF_E008;
    early_exit("R6 sp misaligned", enc(9'd1, 5'd31, 5'd2), 1'b1, 0, 1);
    early_exit("R11 undef beats misaligned sp", enc(9'd1, 5'd31, 5'd2) | 32'h0000_0800, 1'b1, 1, 0);
    early_exit("R11 feature off beats misaligned sp", enc(9'd1, 5'd31, 5'd2), 1'b0, 1, 0);
    regs[15] = 64'h0000_0000_0000_1237;
    load_ok("R6 gpr misaligned is fine", 9'd0, 5'd15, 5'd16);
    sp_val = 64'h0000_7FFF_FFFF_E000;
    test_busy_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule